// File: doc/BRIEF.md
# Phase-Frequency Detector with Loop Direction Control

This block compares two already-divided pulse trains, one taken from the RF divider and one from the reference divider, and turns their relative timing into two pump control lines. One line asks the external charge pump to source current and the other asks it to sink current. Everything runs on a single system clock. Both pulse inputs are sampled and their rising edges are detected on that clock, so phase is resolved to one clock period. The detector has no dead band: when both edges land in the same cycle, each pump line still gives a one-cycle pulse.

A loop-direction input lets the same block serve loops whose VCO tuning slope has either sign. It swaps which comparison result drives the source line and which drives the sink line. It also swaps the two registered monitor outputs, so that an external detector wired to them sees the same reversal. The block has three more functions. A detector enable holds both pump lines low. A 2-bit gain code is decoded into a one-hot multiplier select and a multiplier value expressed in halves. A lock judge watches each finished correction pulse, counts narrow pulses towards a lock verdict and counts wide pulses towards an unlock verdict.

There is no streaming data path in this block. Every pin is a plain level control or status signal, with no valid/ready handshake and no back-pressure.

Top module: `pfd_steer`

## Requirements
- R1: If the RF and reference rising edges are detected in the same clock, `pump_up` and `pump_dn` are each high for exactly one cycle.
- R2: With `dir_sel` high, an RF edge that leads the reference edge by d cycles makes `pump_dn` (sink) high for d+1 cycles and `pump_up` high for 1 cycle. An RF edge that lags by d cycles makes `pump_up` (source) high for d+1 cycles and `pump_dn` high for 1 cycle.
- R3: With `dir_sel` low, the roles in R2 are exchanged: RF lead drives `pump_up` for d+1 cycles and RF lag drives `pump_dn` for d+1 cycles.
- R4: `gain_code` 00, 01, 10 and 11 select multipliers 1.0, 1.5, 2.5 and 4.0. The code sets `mult_sel` bit 0, 1, 2 or 3 respectively, and `mult_half` equals 2, 3, 5 or 8.
- R5: While `pd_en` is low, `pump_up` and `pump_dn` are both low.
- R6: While `mon_en` is high, `mon_p` is the divided RF delayed by one clock and `mon_q` is the divided reference delayed by one clock when `dir_sel` is high. The two are exchanged when `dir_sel` is low. While `mon_en` is low, both outputs are low.
- R7: Each internal correction flop is set only by a rising edge of its own input, so a held level does not set it again. Both flops clear together one clock after both are set, and a correction pulse is the number of cycles the leading flop was high.
- R8: A correction pulse of width no greater than `narrow_max` counts as good. While unlocked, `locked` rises when `lock_len` consecutive good pulses complete, and a wide pulse restarts the count.
- R9: While locked, `locked` falls when max(1, floor(`lock_len`/3)) consecutive wide pulses complete, and a good pulse restarts that count.
- R10: After reset, `pump_up`, `pump_dn`, `mon_p`, `mon_q` and `locked` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rf_div | input | 1 | Divided RF pulse train |
| ref_div | input | 1 | Divided reference pulse train |
| dir_sel | input | 1 | Loop direction; high = sink on RF lead |
| pd_en | input | 1 | Detector enable for the pump lines |
| mon_en | input | 1 | Enable for the monitor outputs |
| gain_code | input | 2 | Pump current multiplier code |
| lock_len | input | CNT_W | Good pulses needed for lock |
| narrow_max | input | WID_W | Widest pulse still judged good, in cycles |
| pump_up | output | 1 | Request pump source current |
| pump_dn | output | 1 | Request pump sink current |
| mon_p | output | 1 | Monitor: divided RF (dir high) or reference |
| mon_q | output | 1 | Monitor: divided reference (dir high) or RF |
| mult_sel | output | 4 | One-hot multiplier select |
| mult_half | output | 4 | Selected multiplier in units of 0.5 |
| locked | output | 1 | Lock indication |

## Verification
A correction flop left set or wrongly cleared shows up as a pump pulse count within the same reference window. A stuck flop instead keeps one pump line high into the next window. A wrong polarity choice or a missed monitor swap appears as exchanged pulse widths on the first comparison after `dir_sel` changes. A miscounting lock or unlock counter changes the cycle on which `locked` moves. This is visible only at the lock_len-th or ulimit-th completed pulse, so the bench runs sequences whose runs are broken one pulse short of each limit.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  localparam int NUM_GAIN = 4;

  typedef enum logic [1:0] {
    GAIN_X1_0 = 2'b00,
    GAIN_X1_5 = 2'b01,
    GAIN_X2_5 = 2'b10,
    GAIN_X4_0 = 2'b11
  } gain_e;

  // multiplier in units of one half
  function automatic logic [3:0] gain_halves(input gain_e g);
    case (g)
      GAIN_X1_0: gain_halves = 4'd2;
      GAIN_X1_5: gain_halves = 4'd3;
      GAIN_X2_5: gain_halves = 4'd5;
      default:   gain_halves = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/pfd_flops.sv
module pfd_flops (
  input  logic clk,
  input  logic rst_n,
  input  logic rf_in,
  input  logic ref_in,
  output logic rf_q,
  output logic ref_q,
  output logic hold_rf,
  output logic hold_ref,
  output logic done
);

  logic rf_edge;
  logic ref_edge;

  assign rf_edge  = rf_in  & ~rf_q;
  assign ref_edge = ref_in & ~ref_q;
  assign done     = hold_rf & hold_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_q     <= 1'b0;
      ref_q    <= 1'b0;
      hold_rf  <= 1'b0;
      hold_ref <= 1'b0;
    end else begin
      rf_q  <= rf_in;
      ref_q <= ref_in;
      if (done) begin
        hold_rf  <= 1'b0;
        hold_ref <= 1'b0;
      end else begin
        hold_rf  <= hold_rf  | rf_edge;
        hold_ref <= hold_ref | ref_edge;
      end
    end
  end

  AST_RF_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_in && !rf_q && !(hold_rf && hold_ref)) |=> hold_rf); // R7

  AST_OVERLAP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_rf && hold_ref) |=> !(hold_rf || hold_ref)); // R7

endmodule

// File: rtl/pfd_gain_dec.sv
module pfd_gain_dec
  import pfd_pkg::*;
(
  input  logic [1:0] gain_code,
  output logic [NUM_GAIN-1:0] mult_sel,
  output logic [3:0] mult_half
);

  for (genvar g = 0; g < NUM_GAIN; g++) begin : g_sel
    assign mult_sel[g] = (gain_code == 2'(g));
  end

  assign mult_half = gain_halves(gain_e'(gain_code));

  always_comb begin
    AST_GAIN_ONEHOT: assert ($countones(mult_sel) == 1); // R4
  end

endmodule

// File: rtl/pfd_lock_judge.sv
module pfd_lock_judge #(
  parameter int CNT_W = 8,
  parameter int WID_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_a,
  input  logic             hold_b,
  input  logic [CNT_W-1:0] lock_len,
  input  logic [WID_W-1:0] narrow_max,
  output logic             locked
);

  logic [WID_W-1:0] wcnt;
  logic [WID_W:0]   w_now;
  logic             evt;
  logic             good_evt;
  logic             bad_evt;
  logic [CNT_W-1:0] run;
  logic [CNT_W:0]   run_nx;
  logic [CNT_W-1:0] third;
  logic [CNT_W-1:0] ulim;

  assign evt      = hold_a & hold_b;
  assign w_now    = {1'b0, wcnt} + 1'b1;
  assign good_evt = evt && (w_now <= {1'b0, narrow_max});
  assign bad_evt  = evt && !good_evt;
  assign run_nx   = {1'b0, run} + 1'b1;
  assign third    = lock_len / CNT_W'(3);
  assign ulim     = (third == '0) ? CNT_W'(1) : third;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt <= '0;
    end else if (evt) begin
      wcnt <= '0;
    end else if ((hold_a | hold_b) && (wcnt != '1)) begin
      wcnt <= wcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      run    <= '0;
    end else if (!locked) begin
      if (good_evt) begin
        if (run_nx >= {1'b0, lock_len}) begin
          locked <= 1'b1;
          run    <= '0;
        end else begin
          run <= run_nx[CNT_W-1:0];
        end
      end else if (bad_evt) begin
        run <= '0;
      end
    end else begin
      if (bad_evt) begin
        if (run_nx >= {1'b0, ulim}) begin
          locked <= 1'b0;
          run    <= '0;
        end else begin
          run <= run_nx[CNT_W-1:0];
        end
      end else if (good_evt) begin
        run <= '0;
      end
    end
  end

  AST_LOCK_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(good_evt)); // R8

  AST_UNLOCK_ON_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(bad_evt)); // R9

endmodule

// File: rtl/pfd_steer.sv
module pfd_steer
  import pfd_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int WID_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rf_div,
  input  logic             ref_div,
  input  logic             dir_sel,
  input  logic             pd_en,
  input  logic             mon_en,
  input  logic [1:0]       gain_code,
  input  logic [CNT_W-1:0] lock_len,
  input  logic [WID_W-1:0] narrow_max,
  output logic             pump_up,
  output logic             pump_dn,
  output logic             mon_p,
  output logic             mon_q,
  output logic [3:0]       mult_sel,
  output logic [3:0]       mult_half,
  output logic             locked
);

  logic rf_q;
  logic ref_q;
  logic hold_rf;
  logic hold_ref;
  logic done;
  logic src_raw;
  logic snk_raw;

  pfd_flops i_flops (
    .clk      (clk),
    .rst_n    (rst_n),
    .rf_in    (rf_div),
    .ref_in   (ref_div),
    .rf_q     (rf_q),
    .ref_q    (ref_q),
    .hold_rf  (hold_rf),
    .hold_ref (hold_ref),
    .done     (done)
  );

  // dir high: RF lead -> sink, reference lead -> source
  assign snk_raw = dir_sel ? hold_rf  : hold_ref;
  assign src_raw = dir_sel ? hold_ref : hold_rf;
  assign pump_up = pd_en & src_raw;
  assign pump_dn = pd_en & snk_raw;

  assign mon_p = mon_en & (dir_sel ? rf_q  : ref_q);
  assign mon_q = mon_en & (dir_sel ? ref_q : rf_q);

  pfd_gain_dec i_gain (
    .gain_code (gain_code),
    .mult_sel  (mult_sel),
    .mult_half (mult_half)
  );

  pfd_lock_judge #(
    .CNT_W (CNT_W),
    .WID_W (WID_W)
  ) i_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold_a     (hold_rf),
    .hold_b     (done | hold_ref),
    .lock_len   (lock_len),
    .narrow_max (narrow_max),
    .locked     (locked)
  );

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_en |-> (!pump_up && !pump_dn)); // R5

  AST_MON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |-> (!mon_p && !mon_q)); // R6

  AST_PUMP_BOTH_BRIEF: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up && pump_dn) |=> !(pump_up && pump_dn)); // R1

endmodule

// File: tb/test_pfd_steer.sv
module test_pfd_steer;

  localparam int CNT_W = 8;
  localparam int WID_W = 6;
  localparam int P     = 16;
  localparam int BASE  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rf_div = 1'b0, ref_div = 1'b0;
  logic dir_sel = 1'b1, pd_en = 1'b1, mon_en = 1'b1;
  logic [1:0] gain_code = 2'b00;
  logic [CNT_W-1:0] lock_len = 8'd6;
  logic [WID_W-1:0] narrow_max = 6'd2;
  logic pump_up, pump_dn, mon_p, mon_q, locked;
  logic [3:0] mult_sel, mult_half;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;
  int n_up, n_dn, n_mp, n_mq;

  always #5 clk = ~clk;

  pfd_steer #(.CNT_W(CNT_W), .WID_W(WID_W)) i_pfd_steer (
    .clk(clk), .rst_n(rst_n), .rf_div(rf_div), .ref_div(ref_div),
    .dir_sel(dir_sel), .pd_en(pd_en), .mon_en(mon_en), .gain_code(gain_code),
    .lock_len(lock_len), .narrow_max(narrow_max), .pump_up(pump_up),
    .pump_dn(pump_dn), .mon_p(mon_p), .mon_q(mon_q), .mult_sel(mult_sel),
    .mult_half(mult_half), .locked(locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rf_div = 1'b0; ref_div = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one reference window; RF edge at BASE+d (2 cycles wide), ref at BASE (3 wide)
  task automatic window(input int d);
    n_up = 0; n_dn = 0; n_mp = 0; n_mq = 0;
    for (int t = 0; t < P; t++) begin
      @(negedge clk);
      ref_div = (t >= BASE) && (t < BASE + 3);
      rf_div  = (t >= BASE + d) && (t < BASE + d + 2);
      @(posedge clk);
      #1;
      n_up += int'(pump_up);
      n_dn += int'(pump_dn);
      n_mp += int'(mon_p);
      n_mq += int'(mon_q);
    end
  endtask

  initial begin
    int seq_a [0:18] = '{0,0,0,0,0, 2, 1,0,1,0,-1, 0, 3, 0, -2, -3, 0, 0, 1};
    int lk, run, ulim, w;
    do_reset();
    @(posedge clk); #1;
    // R10 reset state
    chk("R10 pump_up", int'(pump_up), 0);
    chk("R10 pump_dn", int'(pump_dn), 0);
    chk("R10 mon_p", int'(mon_p), 0);
    chk("R10 mon_q", int'(mon_q), 0);
    chk("R10 locked", int'(locked), 0);

    // R4 gain decode sweep
    for (int g = 0; g < 4; g++) begin
      int halves;
      gain_code = 2'(g);
      #1;
      halves = (g == 0) ? 2 : (g == 1) ? 3 : (g == 2) ? 5 : 8;
      chk("R4 mult_sel", int'(mult_sel), 1 << g);
      chk("R4 mult_half", int'(mult_half), halves);
    end

    // pump and monitor sweep: R1 R2 R3 R5 R6 R7
    for (int dr = 0; dr < 2; dr++) begin
      for (int pe = 0; pe < 2; pe++) begin
        for (int me = 0; me < 2; me++) begin
          for (int d = -3; d <= 3; d++) begin
            int rfw, refw, eu, ed, ep, eq;
            dir_sel = dr[0]; pd_en = pe[0]; mon_en = me[0];
            window(d);
            rfw  = (d < 0) ? -d + 1 : 1;
            refw = (d > 0) ?  d + 1 : 1;
            if (pe == 0) begin eu = 0; ed = 0; end
            else if (dr == 1) begin eu = refw; ed = rfw; end
            else begin eu = rfw; ed = refw; end
            if (me == 0) begin ep = 0; eq = 0; end
            else if (dr == 1) begin ep = 2; eq = 3; end
            else begin ep = 3; eq = 2; end
            if (pe == 0) begin
              chk("R5 pump_up", n_up, eu);
              chk("R5 pump_dn", n_dn, ed);
            end else if (d == 0) begin
              chk("R1 pump_up", n_up, eu);
              chk("R1 pump_dn", n_dn, ed);
            end else if (dr == 1) begin
              chk("R2 pump_up", n_up, eu);
              chk("R2 pump_dn", n_dn, ed);
            end else begin
              chk("R3 pump_up R7", n_up, eu);
              chk("R3 pump_dn R7", n_dn, ed);
            end
            chk("R6 mon_p", n_mp, ep);
            chk("R6 mon_q", n_mq, eq);
          end
        end
      end
    end

    // lock judge: R8 R9, lock_len 6 then 3
    for (int pass = 0; pass < 2; pass++) begin
      dir_sel = 1'b1; pd_en = 1'b1; mon_en = 1'b0;
      lock_len = (pass == 0) ? 8'd6 : 8'd3;
      narrow_max = 6'd2;
      do_reset();
      lk = 0; run = 0;
      ulim = (int'(lock_len) / 3 == 0) ? 1 : int'(lock_len) / 3;
      for (int k = 0; k < 19; k++) begin
        bit good;
        window(seq_a[k]);
        w = (seq_a[k] < 0 ? -seq_a[k] : seq_a[k]) + 1;
        good = (w <= int'(narrow_max));
        if (lk == 0) begin
          if (good) begin
            run++;
            if (run >= int'(lock_len)) begin lk = 1; run = 0; end
          end else run = 0;
          chk("R8 locked", int'(locked), lk);
        end else begin
          if (!good) begin
            run++;
            if (run >= ulim) begin lk = 0; run = 0; end
          end else run = 0;
          chk("R9 locked", int'(locked), lk);
        end
      end
    end

    finish_run();
  end

endmodule